// File: doc/BRIEF.md
# Round-Robin Arbiter with Grant Hold and Request Exclusion

This block shares one resource among `WIDTH` requestors. Each requestor raises its bit of `req`. The arbiter answers with a one-hot `grant`, and the grant stays with its owner until that owner lowers its request. The arbiter then moves on, in rotating order, to the next requestor at a higher bit index. After the highest index it wraps back to bit 0. When no request is raised, no grant is given. Request bits that are not raised are skipped in the same cycle, so no cycle is lost on an empty slot.

A per-bit `req_mask` lets the surrounding logic keep individual requestors out of arbitration. The arbiter stores the last non-zero grant in a register and brings it out on `grant_prev`. The rotation works from that register.

After a cycle in which every request was low, the arbiter does not continue the rotation. It picks the lowest eligible index, but never the last owner in that first cycle. This keeps a requestor that pulses its request from taking the resource again ahead of the others. A synchronous `clear` erases the stored history.

Top module: `rr_hold_arbiter`

## Requirements
- R1: Bit 0 has the highest priority. When there is no history (after `clear`), the grant goes to the lowest-index bit of `req & req_mask` in the same cycle.
- R2: `grant` is either zero or a single bit, and it is always contained in `req & req_mask`.
- R3: A requestor granted in one cycle keeps the grant in the next cycle while its bit of `req & req_mask` stays high and `clear` is low.
- R4: When the owner releases, the grant goes to the lowest eligible index above the last granted index. If there is none, it wraps to the lowest eligible index overall.
- R5: A requestor whose `req_mask` bit is 0 is never granted. With `req_mask` all ones, arbitration depends on `req` alone.
- R6: `grant_prev` takes the value of `grant` at each rising edge where `grant` is non-zero. It keeps its value across edges where `grant` is zero.
- R7: In the first cycle after a cycle with `req` all zero, the grant is the lowest-index eligible request other than the bit in `grant_prev`. If only that bit is eligible, the grant is zero for that cycle.
- R8: `clear` high at a rising edge sets `grant_prev` to zero and marks the history idle, so arbitration restarts from bit 0.
- R9: If the previous cycle had any request raised and was not a clear cycle, a non-zero `req & req_mask` gives a non-zero grant.
- R10: When requestors keep requesting and each releases after one grant, every requestor is served within `WIDTH` grants.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clear | input | 1 | Synchronous clear of the arbitration history |
| req | input | WIDTH | One request bit per requestor |
| req_mask | input | WIDTH | Eligibility per requestor; 0 excludes the requestor |
| grant | output | WIDTH | One-hot grant, combinational from the inputs and the state |
| grant_prev | output | WIDTH | Registered last non-zero grant |

## Verification
`grant` is combinational. It is due in the same cycle that `req` or `req_mask` changes, so each check drives its inputs on the falling edge and samples `grant` a few time units later, before the next rising edge. `grant_prev` and the idle history change one rising edge after the grant that feeds them. The expected grant of each vector therefore includes the history left by the row before it. The post-idle and post-clear checks are placed in the cycle directly after the idle or clear cycle. The rotation test works out each expected grant from the one before it.

// File: rtl/rr_arb_pkg.sv
package rr_arb_pkg;
  // Rotate a one-hot vector one place towards higher index, wrapping to bit 0.
  function automatic logic [63:0] rotl1(input logic [63:0] v, input int unsigned w);
    logic [63:0] r;
    r = '0;
    for (int unsigned i = 0; i < 64; i++) begin
      if (i < w) r[(i + 1) % w] = v[i];
    end
    return r;
  endfunction
endpackage

// File: rtl/rr_first_one.sv
// Picks the lowest-index set bit of a vector and returns it one-hot.
module rr_first_one #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] vec,
  output logic [WIDTH-1:0] pick,
  output logic             any
);
  logic [WIDTH:0] seen;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_chain
    assign pick[i]     = vec[i] & ~seen[i];
    assign seen[i + 1] = seen[i] | vec[i];
  end

  assign any = seen[WIDTH];
endmodule

// File: rtl/rr_thermo.sv
// Builds the mask of bits strictly above the index of a one-hot input.
// A zero input gives a zero mask.
module rr_thermo #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] onehot,
  output logic [WIDTH-1:0] above
);
  logic [WIDTH:0] below_or_at;

  assign below_or_at[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_therm
    assign above[i]           = below_or_at[i];
    assign below_or_at[i + 1] = below_or_at[i] | onehot[i];
  end
endmodule

// File: rtl/rr_history.sv
// Stores the last non-zero grant and whether the previous cycle was idle.
module rr_history #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             clear,
  input  logic [WIDTH-1:0] grant,
  input  logic             any_req,
  output logic [WIDTH-1:0] last_grant,
  output logic             was_idle
);
  always_ff @(posedge clk) begin
    if (clear) begin
      last_grant <= '0;
      was_idle   <= 1'b1;
    end else begin
      if (|grant) last_grant <= grant;
      was_idle <= ~any_req;
    end
  end

  // R6: the history only moves when a grant is issued
  p_keep_history_r6: assert property (@(posedge clk) disable iff (clear)
    (grant == '0) |=> (last_grant == $past(last_grant)));

  // R8: clear wipes the stored grant
  p_clear_wipes_r8: assert property (@(posedge clk)
    clear |=> (last_grant == '0));
endmodule

// File: rtl/rr_hold_arbiter.sv
module rr_hold_arbiter #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             clear,
  input  logic [WIDTH-1:0] req,
  input  logic [WIDTH-1:0] req_mask,
  output logic [WIDTH-1:0] grant,
  output logic [WIDTH-1:0] grant_prev
);
  logic [WIDTH-1:0] eligible;
  logic [WIDTH-1:0] last_grant;
  logic             was_idle;
  logic [WIDTH-1:0] above_last;
  logic [WIDTH-1:0] rr_window;
  logic [WIDTH-1:0] rr_cand;
  logic [WIDTH-1:0] rr_pick;
  logic             rr_any;
  logic [WIDTH-1:0] fb_pick;
  logic             fb_any;

  assign eligible = req & req_mask;

  rr_history #(.WIDTH(WIDTH)) i_history (
    .clk        (clk),
    .clear      (clear),
    .grant      (grant),
    .any_req    (|req),
    .last_grant (last_grant),
    .was_idle   (was_idle)
  );

  rr_thermo #(.WIDTH(WIDTH)) i_thermo (
    .onehot (last_grant),
    .above  (above_last)
  );

  // Normal rotation: bits after the last owner, plus the owner itself
  // so that a held grant is not taken away. After an idle cycle the
  // window is everything except the last owner.
  always_comb begin
    if (was_idle) rr_window = ~last_grant;
    else          rr_window = above_last | last_grant;
    rr_cand = eligible & rr_window;
  end

  rr_first_one #(.WIDTH(WIDTH)) i_pick_rr (
    .vec  (rr_cand),
    .pick (rr_pick),
    .any  (rr_any)
  );

  rr_first_one #(.WIDTH(WIDTH)) i_pick_fb (
    .vec  (eligible),
    .pick (fb_pick),
    .any  (fb_any)
  );

  always_comb begin
    if (rr_any)                  grant = rr_pick;
    else if (fb_any && !was_idle) grant = fb_pick;
    else                         grant = '0;
  end

  assign grant_prev = last_grant;

  // R2: at most one grant, and only to an eligible requestor
  p_onehot_r2: assert property (@(posedge clk) disable iff (clear)
    $onehot0(grant));
  p_subset_r2: assert property (@(posedge clk) disable iff (clear)
    ((grant & ~(req & req_mask)) == '0));

  // R3: an owner that still requests keeps the grant
  p_hold_r3: assert property (@(posedge clk) disable iff (clear)
    (!$past(clear) && ((req & req_mask & $past(grant)) != '0)) |-> (grant == $past(grant)));

  // R9: no idle slot while busy after a busy cycle
  p_busy_r9: assert property (@(posedge clk) disable iff (clear)
    (!$past(clear) && $past(|req) && (|(req & req_mask))) |-> (|grant));
endmodule

// File: tb/test_rr_hold_arbiter.sv
module test_rr_hold_arbiter;
  localparam int unsigned W          = 4;
  localparam time         CLK_PERIOD = 10;
  localparam int unsigned NROWS      = 23;

  // Each row: {req, req_mask, expected grant}, applied in sequence after clear.
  localparam logic [11:0] VEC [NROWS] = '{
    12'b0000_1111_0000, // R1 idle: no grant
    12'b0110_1111_0010, // R7 first after idle, lowest index
    12'b0110_1111_0010, // R3 hold
    12'b0100_1111_0100, // R4 next above
    12'b0101_1111_0100, // R3 hold
    12'b0001_1111_0001, // R4 wrap
    12'b1001_1111_0001, // R3 hold
    12'b1000_1111_1000, // R4 next above
    12'b1011_1111_1000, // R3 hold
    12'b0011_1111_0001, // R4 wrap to lowest
    12'b0010_1111_0010, // R4
    12'b0110_1011_0010, // R5 masked bit ignored
    12'b0100_1011_0000, // R5 only masked request: no grant
    12'b0100_1111_0100, // R6 history kept across zero grant
    12'b0000_1111_0000, // idle
    12'b0101_1111_0001, // R7 restart at top, not continue
    12'b0100_1111_0100, // R4
    12'b0000_1111_0000, // idle
    12'b0100_1111_0000, // R7 last owner refused
    12'b0100_1111_0100, // R9 granted next cycle
    12'b1111_1111_0100, // R3 hold
    12'b1011_1111_1000, // R4
    12'b0111_1111_0001  // R4 wrap
  };

  logic         clk = 1'b0;
  logic         clear;
  logic [W-1:0] req;
  logic [W-1:0] req_mask;
  logic [W-1:0] grant;
  logic [W-1:0] grant_prev;

  int unsigned  n_tests = 0;
  int unsigned  n_fail  = 0;
  bit           done    = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rr_hold_arbiter #(.WIDTH(W)) i_rr_hold_arbiter (
    .clk        (clk),
    .clear      (clear),
    .req        (req),
    .req_mask   (req_mask),
    .grant      (grant),
    .grant_prev (grant_prev)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [W-1:0] r, input logic [W-1:0] m);
    @(negedge clk);
    req      = r;
    req_mask = m;
    #2;
  endtask

  initial begin
    clear    = 1'b1;
    req      = '0;
    req_mask = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    clear = 1'b0;
    #2;
    check("R8 reset grant_prev", grant_prev, '0);
    check("R1 reset grant", grant, '0);

    for (int i = 0; i < NROWS; i++) begin
      drive(VEC[i][11:8], VEC[i][7:4]);
      check($sformatf("R2/R3/R4/R5/R7 row %0d", i), grant, VEC[i][3:0]);
    end

    // R6: after row 22 the last non-zero grant is bit 0
    drive('0, '1);
    check("R6 grant_prev held", grant_prev, 4'b0001);

    // R8: clear forgets the last owner; bit 0 then wins at once
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    req   = 4'b0001;
    #2;
    check("R8 grant_prev cleared", grant_prev, '0);
    check("R8 R1 grant after clear", grant, 4'b0001);

    // R10: each owner releases after one grant; service rotates
    begin
      logic [W-1:0] exp_g;
      logic [W-1:0] last_g;
      last_g = 4'b0001;
      for (int k = 0; k < 3 * W; k++) begin
        exp_g = (last_g << 1) | (last_g >> (W - 1));
        drive(4'b1111 & ~last_g, '1);
        check($sformatf("R10 rotation step %0d", k), grant, exp_g);
        last_g = exp_g;
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule